// File: doc/BRIEF.md
# Half-Duplex Smart-Card UART with Parity Error Signalling

This block is an asynchronous serial transceiver for a single open-drain line shared by both directions, as used on SIM and smart-card contacts. A programmable prescaler produces sixteen sub-ticks per bit. The transmit side has a one-word holding buffer that feeds an eleven-bit shift register. The receive side assembles bits in a shift register and then moves the finished byte into a receive buffer. Every frame uses even parity.

The block also signals errors on the line. When a received frame fails its parity check, the receiver pulls the shared line low for the whole stop-bit slot. The transmitter samples the line in the middle of its own stop bit, so it sees the echo of its own frame, including any such low level. It records a low stop bit as a transmit error. The transmit interrupt request can be raised in one of two ways: when the holding buffer hands its word to the shift register, or when the shift register has sent the last bit.

The line interface is open-drain: `lineOutLow` high means the block pulls the wire low, and `lineIn` is the resolved wire level.

Top module: `scUart`

## Requirements
- R1: One bit lasts exactly 16 × (baudDiv + 1) clock cycles. baudDiv = 0 gives 16 cycles per bit.
- R2: A transmitted frame has 11 bit slots, numbered 0 to 10 in time order. Slot 0 is a low start bit. Slots 1 to 8 carry data bits 0 to 7, least significant bit first. Slot 9 is a parity bit equal to the XOR of the eight data bits (even parity). Slot 10 is a high stop bit. A line level of 0 means lineOutLow = 1.
- R3: After a write to the holding buffer, the start bit does not begin in the cycle of the write. It waits for the next prescaler overflow, so the line first reads low between 2 and baudDiv + 2 cycles after the write strobe was driven.
- R4: txBufEmpty is 1 after reset. A txWrite pulse clears it. It returns to 1 in the same cycle that the word moves into the shift register, which is the cycle the start bit begins.
- R5: txRegEmpty is 1 whenever no frame is being sent and 0 for the whole of a frame. When a new frame is waiting in the holding buffer, it stays 0 across the gap between two frames sent back to back, and the next start bit follows the previous stop bit with no idle time.
- R6: With txIrqSel = 0, txIrq is set when the holding buffer empties into the shift register. With txIrqSel = 1, txIrq is set only when the stop bit of a frame has finished. txIrqClr clears txIrq.
- R7: The receiver checks even parity on each incoming frame. On a mismatch it sets parityErr and pulls the line low for the stop-bit slot only. It does not pull the line low during the parity slot, after the stop slot, or on frames whose parity is correct.
- R8: The transmitter samples the line in the middle of its stop bit. If the line is low there, it sets txErr. Because both directions share one wire, the receiver also takes in the block's own transmitted frames when it is enabled.
- R9: The receiver detects a start bit from a falling edge and samples each bit in the middle of its slot. At the end of the stop slot it copies the byte to rxData and sets rxComplete and rxIrq. rxRead clears rxComplete, rxIrqClr clears rxIrq, and errClr clears parityErr and txErr.
- R10: No frame starts while txEnable = 0; a written word waits in the holding buffer. While rxEnable = 0, incoming frames change neither rxData nor rxComplete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the prescaler count source |
| rstN | input | 1 | Asynchronous reset, active low |
| baudDiv | input | 8 | Prescaler divisor n, giving a bit period of 16(n+1) cycles |
| txEnable | input | 1 | Allows frames to start |
| rxEnable | input | 1 | Allows frame reception |
| txIrqSel | input | 1 | 0: interrupt when the buffer empties, 1: interrupt when a frame completes |
| txWrite | input | 1 | Write strobe for the holding buffer |
| txData | input | 8 | Byte to transmit |
| rxRead | input | 1 | Receive buffer read strobe, clears rxComplete |
| rxIrqClr | input | 1 | Clears rxIrq |
| txIrqClr | input | 1 | Clears txIrq |
| errClr | input | 1 | Clears parityErr and txErr |
| lineIn | input | 1 | Resolved level of the shared wire |
| lineOutLow | output | 1 | 1 pulls the shared wire low |
| rxData | output | 8 | Last received byte |
| txBufEmpty | output | 1 | Holding buffer free |
| txRegEmpty | output | 1 | No frame in progress |
| rxComplete | output | 1 | A received byte is waiting |
| parityErr | output | 1 | A received frame had bad parity |
| txErr | output | 1 | A low stop bit was seen while sending |
| txIrq | output | 1 | Transmit interrupt request |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
A transmitted frame's start bit first shows on lineOutLow half a cycle after the prescaler overflow that loads it. The bench finds that edge, then reads bit slot i at 32i + 16 cycles later, in the middle of each slot when baudDiv = 1. txBufEmpty and, with txIrqSel = 0, txIrq change in the same cycle as the start edge, so the bench checks them right there. The frame-complete interrupt and txRegEmpty are checked a few cycles after slot 10 closes. Received bytes pass through a two-stage synchronizer plus one edge register, so the receiver's stop slot and its error drive lag the card's by three to five cycles. The bench therefore checks the error drive at the middle of the card's stop slot and checks its release 24 cycles after the card's stop ends. Bit length and start latency are measured in whole cycles against 16(n+1) and against the window of 2 to n+2 cycles.

// File: rtl/scUartPkg.sv
package scUartPkg;
  // Strobes and levels that the sequencer hands to the datapath each cycle.
  typedef struct packed {
    logic txLoad;          // move holding buffer into shift register
    logic txShift;         // advance to next bit slot
    logic txStopSample;    // middle of own stop slot
    logic txDone;          // last sub-tick of own stop slot
    logic txActive;        // a frame is on the wire
    logic rxShiftIn;       // middle of a data slot
    logic rxParitySample;  // middle of the parity slot
    logic rxFinish;        // end of the stop slot
    logic rxDrive;         // pull the wire low (error signal)
  } ctlStrobe_t;
endpackage

// File: rtl/scUartBaud.sv
module scUartBaud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] baudDiv,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= baudDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (tick && baudDiv != '0) |=> (!tick || baudDiv != $past(baudDiv))); // R1
endmodule

// File: rtl/scUartCtl.sv
module scUartCtl
  import scUartPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       txEnable,
  input  logic       rxEnable,
  input  logic       txPending,
  input  logic       lineLevel,
  input  logic       lineFall,
  input  logic       parityBadNow,
  output ctlStrobe_t strb
);
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int SUB_W      = $clog2(OVERSAMPLE);
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(OVERSAMPLE - 1);
  localparam logic [SUB_W-1:0] SUB_MID   = SUB_W'(OVERSAMPLE / 2 - 1);
  localparam logic [BIT_W-1:0] STOP_IDX  = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] PAR_IDX   = BIT_W'(FRAME_BITS - 2);
  localparam logic [BIT_W-1:0] DATA_FIRST = BIT_W'(1);
  localparam logic [BIT_W-1:0] DATA_LAST  = BIT_W'(DATA_W);

  // ---------------- transmit sequencing ----------------
  logic             txActive;
  logic [SUB_W-1:0] txSub;
  logic [BIT_W-1:0] txBit;
  logic             txLast;
  logic             txLoad;

  assign txLast = txActive && (txSub == SUB_LAST) && (txBit == STOP_IDX);
  assign txLoad = tick && txEnable && txPending && (!txActive || txLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txActive <= 1'b0;
      txSub    <= '0;
      txBit    <= '0;
    end else if (txLoad) begin
      txActive <= 1'b1;
      txSub    <= '0;
      txBit    <= '0;
    end else if (tick && txActive) begin
      if (txLast) txActive <= 1'b0;
      if (txSub == SUB_LAST) begin
        txSub <= '0;
        txBit <= txBit + 1'b1;
      end else begin
        txSub <= txSub + 1'b1;
      end
    end
  end

  // ---------------- receive sequencing ----------------
  logic             rxActive;
  logic             rxErrPend;
  logic             rxDrive;
  logic [SUB_W-1:0] rxSub;
  logic [BIT_W-1:0] rxBit;
  logic             rxMid;

  assign rxMid = tick && rxActive && (rxSub == SUB_MID);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxActive  <= 1'b0;
      rxErrPend <= 1'b0;
      rxDrive   <= 1'b0;
      rxSub     <= '0;
      rxBit     <= '0;
    end else if (!rxEnable) begin
      rxActive  <= 1'b0;
      rxErrPend <= 1'b0;
      rxDrive   <= 1'b0;
    end else if (!rxActive) begin
      if (lineFall) begin
        rxActive  <= 1'b1;
        rxErrPend <= 1'b0;
        rxSub     <= '0;
        rxBit     <= '0;
      end
    end else if (tick) begin
      if (rxSub == SUB_MID && rxBit == '0 && lineLevel) rxActive <= 1'b0;
      if (rxSub == SUB_MID && rxBit == PAR_IDX) rxErrPend <= parityBadNow;
      if (rxSub == SUB_LAST) begin
        rxSub <= '0;
        if (rxBit == STOP_IDX) begin
          rxActive <= 1'b0;
          rxDrive  <= 1'b0;
        end else begin
          rxBit <= rxBit + 1'b1;
          if (rxBit == PAR_IDX) rxDrive <= rxErrPend;
        end
      end else begin
        rxSub <= rxSub + 1'b1;
      end
    end
  end

  always_comb begin
    strb.txLoad         = txLoad;
    strb.txShift        = tick && txActive && (txSub == SUB_LAST) && (txBit != STOP_IDX);
    strb.txStopSample   = tick && txActive && (txBit == STOP_IDX) && (txSub == SUB_MID);
    strb.txDone         = tick && txLast;
    strb.txActive       = txActive;
    strb.rxShiftIn      = rxMid && (rxBit >= DATA_FIRST) && (rxBit <= DATA_LAST);
    strb.rxParitySample = rxMid && (rxBit == PAR_IDX);
    strb.rxFinish       = tick && rxActive && (rxSub == SUB_LAST) && (rxBit == STOP_IDX);
    strb.rxDrive        = rxDrive;
  end

  AST_TX_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> $past(txEnable)); // R10
  AST_RX_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !rxDrive); // R10
endmodule

// File: rtl/scUartDp.sv
module scUartDp
  import scUartPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              lineIn,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              txIrqSel,
  input  logic              rxRead,
  input  logic              rxIrqClr,
  input  logic              txIrqClr,
  input  logic              errClr,
  output logic              txPending,
  output logic              lineLevel,
  output logic              lineFall,
  output logic              parityBadNow,
  output logic              lineOutLow,
  output logic              txBufEmpty,
  output logic [DATA_W-1:0] rxData,
  output logic              rxComplete,
  output logic              parityErr,
  output logic              txErr,
  output logic              txIrq,
  output logic              rxIrq
);
  localparam int FRAME_BITS = DATA_W + 3;

  // line synchronizer and edge detect
  logic [1:0] syncQ;
  logic       linePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '1;
      linePrev <= 1'b1;
    end else begin
      syncQ    <= {syncQ[0], lineIn};
      linePrev <= syncQ[1];
    end
  end

  assign lineLevel = syncQ[1];
  assign lineFall  = linePrev && !syncQ[1];

  // transmit holding buffer and shift register
  logic [DATA_W-1:0]     txBuf;
  logic [FRAME_BITS-1:0] txSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf      <= '0;
      txBufEmpty <= 1'b1;
      txSh       <= '1;
    end else begin
      if (txWrite) begin
        txBuf      <= txData;
        txBufEmpty <= 1'b0;
      end else if (strb.txLoad) begin
        txBufEmpty <= 1'b1;
      end
      if (strb.txLoad)       txSh <= {1'b1, ^txBuf, txBuf, 1'b0};
      else if (strb.txShift) txSh <= {1'b1, txSh[FRAME_BITS-1:1]};
    end
  end

  assign txPending  = !txBufEmpty;
  assign lineOutLow = (strb.txActive && !txSh[0]) || strb.rxDrive;

  // receive shift register and buffer
  logic [DATA_W-1:0] rxSh;

  assign parityBadNow = (^rxSh) ^ lineLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh       <= '0;
      rxData     <= '0;
      rxComplete <= 1'b0;
      rxIrq      <= 1'b0;
    end else begin
      if (strb.rxShiftIn) rxSh <= {lineLevel, rxSh[DATA_W-1:1]};
      if (strb.rxFinish) begin
        rxData     <= rxSh;
        rxComplete <= 1'b1;
        rxIrq      <= 1'b1;
      end else begin
        if (rxRead)   rxComplete <= 1'b0;
        if (rxIrqClr) rxIrq      <= 1'b0;
      end
    end
  end

  // flags and transmit interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parityErr <= 1'b0;
      txErr     <= 1'b0;
      txIrq     <= 1'b0;
    end else begin
      if (strb.rxParitySample && parityBadNow) parityErr <= 1'b1;
      else if (errClr)                         parityErr <= 1'b0;
      if (strb.txStopSample && !lineLevel)     txErr <= 1'b1;
      else if (errClr)                         txErr <= 1'b0;
      if ((!txIrqSel && strb.txLoad) || (txIrqSel && strb.txDone)) txIrq <= 1'b1;
      else if (txIrqClr)                                          txIrq <= 1'b0;
    end
  end

  AST_LOAD_EMPTIES_BUF: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txLoad && !txWrite) |=> txBufEmpty); // R4
  AST_LOAD_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |-> !txBufEmpty); // R4
  AST_DRIVE_AFTER_ERR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.rxDrive) |-> parityErr); // R7
  AST_TX_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txErr) |-> $past(strb.txStopSample)); // R8
endmodule

// File: rtl/scUart.sv
module scUart
  import scUartPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic              txIrqSel,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  input  logic              rxIrqClr,
  input  logic              txIrqClr,
  input  logic              errClr,
  input  logic              lineIn,
  output logic              lineOutLow,
  output logic [DATA_W-1:0] rxData,
  output logic              txBufEmpty,
  output logic              txRegEmpty,
  output logic              rxComplete,
  output logic              parityErr,
  output logic              txErr,
  output logic              txIrq,
  output logic              rxIrq
);
  logic       tick;
  logic       txPending;
  logic       lineLevel;
  logic       lineFall;
  logic       parityBadNow;
  ctlStrobe_t strb;

  scUartBaud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .tick(tick)
  );

  scUartCtl #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) ctl_i (
    .clk(clk), .rstN(rstN), .tick(tick),
    .txEnable(txEnable), .rxEnable(rxEnable),
    .txPending(txPending), .lineLevel(lineLevel), .lineFall(lineFall),
    .parityBadNow(parityBadNow), .strb(strb)
  );

  scUartDp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .lineIn(lineIn),
    .txWrite(txWrite), .txData(txData), .txIrqSel(txIrqSel),
    .rxRead(rxRead), .rxIrqClr(rxIrqClr), .txIrqClr(txIrqClr), .errClr(errClr),
    .txPending(txPending), .lineLevel(lineLevel), .lineFall(lineFall),
    .parityBadNow(parityBadNow), .lineOutLow(lineOutLow),
    .txBufEmpty(txBufEmpty), .rxData(rxData), .rxComplete(rxComplete),
    .parityErr(parityErr), .txErr(txErr), .txIrq(txIrq), .rxIrq(rxIrq)
  );

  assign txRegEmpty = !strb.txActive;

  AST_REG_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (txRegEmpty && !rxEnable) |-> !lineOutLow); // R5
endmodule

// File: tb/scUart_tb_top.sv
module scUart_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] baudDiv = 8'd1;
  logic       txEnable = 1'b0, rxEnable = 1'b0, txIrqSel = 1'b0, txWrite = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       rxRead = 1'b0, rxIrqClr = 1'b0, txIrqClr = 1'b0, errClr = 1'b0;
  logic       cardLow = 1'b0;
  logic       lineOutLow, txBufEmpty, txRegEmpty, rxComplete, parityErr, txErr, txIrq, rxIrq;
  logic [7:0] rxData;
  logic       wire_;

  int checks = 0;
  int errors = 0;
  bit regEmptySeen = 0;
  bit dutLowSeen = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign wire_ = !(lineOutLow || cardLow);

  scUart dut_i (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .txEnable(txEnable), .rxEnable(rxEnable),
    .txIrqSel(txIrqSel), .txWrite(txWrite), .txData(txData), .rxRead(rxRead),
    .rxIrqClr(rxIrqClr), .txIrqClr(txIrqClr), .errClr(errClr), .lineIn(wire_),
    .lineOutLow(lineOutLow), .rxData(rxData), .txBufEmpty(txBufEmpty),
    .txRegEmpty(txRegEmpty), .rxComplete(rxComplete), .parityErr(parityErr),
    .txErr(txErr), .txIrq(txIrq), .rxIrq(rxIrq)
  );

  // per-clock observers of the line and of the shift-register flag
  always @(negedge clk) begin
    if (txRegEmpty) regEmptySeen = 1;
    if (lineOutLow) dutLowSeen = 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] frameOf(input logic [7:0] d, input bit badPar);
    return {1'b1, (^d) ^ badPar, d, 1'b0};
  endfunction

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic writeTx(input logic [7:0] d);
    txData = d;
    pulse(txWrite);
  endtask

  task automatic waitTxStart();
    int n = 0;
    while (!lineOutLow && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check(n < 4000, "R2 start bit timeout", n, 0);
  endtask

  // called at the first negedge of a start bit; baudDiv = 1 (32 cycles per bit)
  task automatic captureTx(output logic [10:0] bits, input bit pullStop, output bit regEmptyMid);
    regEmptyMid = 1'b1;
    for (int i = 0; i < 11; i++) begin
      if (i == 10 && pullStop) begin
        repeat (2) @(negedge clk);
        cardLow = 1'b1;
        repeat (14) @(negedge clk);
        bits[i] = wire_;
        repeat (13) @(negedge clk);
        cardLow = 1'b0;
        repeat (3) @(negedge clk);
      end else begin
        repeat (16) @(negedge clk);
        bits[i] = wire_;
        if (i == 5) regEmptyMid = txRegEmpty;
        repeat (16) @(negedge clk);
      end
    end
  endtask

  // card side sends a frame; baudDiv = 1
  task automatic cardSend(input logic [7:0] d, input bit badPar,
                          output bit lowAtPar, output bit lowAtStop, output bit lowAfter);
    logic [10:0] f;
    f = frameOf(d, badPar);
    for (int i = 0; i < 11; i++) begin
      cardLow = !f[i];
      repeat (16) @(negedge clk);
      if (i == 9)  lowAtPar  = lineOutLow;
      if (i == 10) lowAtStop = lineOutLow;
      repeat (16) @(negedge clk);
    end
    cardLow = 1'b0;
    repeat (24) @(negedge clk);
    lowAfter = lineOutLow;
    repeat (16) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [10:0] bits;
    logic [10:0] bits2;
    bit mid, lp, ls, la;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    check(txBufEmpty == 1'b1, "R4 reset txBufEmpty", txBufEmpty, 1);
    check(txRegEmpty == 1'b1, "R5 reset txRegEmpty", txRegEmpty, 1);
    check({rxComplete, parityErr, txErr, txIrq, rxIrq, lineOutLow} == 6'b0,
          "R9 reset flags", {rxComplete, parityErr, txErr, txIrq, rxIrq, lineOutLow}, 0);

    // R10: transmitter disabled, word waits in the buffer
    dutLowSeen = 0;
    writeTx(8'hA5);
    repeat (200) @(negedge clk);
    check(!dutLowSeen, "R10 tx disabled line quiet", dutLowSeen, 0);
    check(txBufEmpty == 1'b0 && txRegEmpty == 1'b1, "R10 tx disabled buffer held",
          {txBufEmpty, txRegEmpty}, 2'b01);

    // R2/R4/R6 sel=0: enable, buffer empties at start, irq raised then
    txIrqSel = 1'b0;
    txEnable = 1'b1;
    waitTxStart();
    check(txBufEmpty == 1'b1, "R4 buffer empty at start", txBufEmpty, 1);
    check(txIrq == 1'b1, "R6 sel0 irq at buffer empty", txIrq, 1);
    captureTx(bits, 1'b0, mid);
    check(bits == frameOf(8'hA5, 0), "R2 frame A5", bits, frameOf(8'hA5, 0));
    check(mid == 1'b0, "R5 regEmpty low mid-frame", mid, 0);
    repeat (4) @(negedge clk);
    check(txRegEmpty == 1'b1, "R5 regEmpty after frame", txRegEmpty, 1);
    check(txErr == 1'b0, "R8 no txErr clean stop", txErr, 0);

    // R6 sel=1: irq only on completion
    pulse(txIrqClr);
    txIrqSel = 1'b1;
    writeTx(8'h3C);
    waitTxStart();
    check(txIrq == 1'b0, "R6 sel1 no irq at load", txIrq, 0);
    captureTx(bits, 1'b0, mid);
    check(bits == frameOf(8'h3C, 0), "R2 frame 3C", bits, frameOf(8'h3C, 0));
    repeat (2) @(negedge clk);
    check(txIrq == 1'b1, "R6 sel1 irq at completion", txIrq, 1);
    pulse(txIrqClr);
    check(txIrq == 1'b0, "R6 txIrqClr", txIrq, 0);

    // R5 back-to-back frames
    writeTx(8'h11);
    waitTxStart();
    writeTx(8'h22);
    regEmptySeen = 0;
    captureTx(bits, 1'b0, mid);
    waitTxStart();
    check(!regEmptySeen, "R5 regEmpty stays low between frames", regEmptySeen, 0);
    captureTx(bits2, 1'b0, mid);
    check(bits == frameOf(8'h11, 0), "R5 first of pair", bits, frameOf(8'h11, 0));
    check(bits2 == frameOf(8'h22, 0), "R5 second of pair", bits2, frameOf(8'h22, 0));
    repeat (4) @(negedge clk);

    // R8: card pulls our stop bit low
    writeTx(8'h5A);
    waitTxStart();
    captureTx(bits, 1'b1, mid);
    check(bits[10] == 1'b0, "R8 stop slot seen low", bits[10], 0);
    repeat (4) @(negedge clk);
    check(txErr == 1'b1, "R8 txErr set", txErr, 1);
    pulse(errClr);
    check(txErr == 1'b0, "R9 errClr clears txErr", txErr, 0);
    txEnable = 1'b0;
    pulse(txIrqClr);

    // R9: good receive, no error drive
    rxEnable = 1'b1;
    repeat (8) @(negedge clk);
    dutLowSeen = 0;
    cardSend(8'h96, 1'b0, lp, ls, la);
    check(!dutLowSeen, "R7 no drive on good parity", dutLowSeen, 0);
    check(rxData == 8'h96 && rxComplete && rxIrq, "R9 receive 96",
          {rxData, rxComplete, rxIrq}, {8'h96, 2'b11});
    check(parityErr == 1'b0, "R7 no parityErr", parityErr, 0);
    pulse(rxRead);
    check(rxComplete == 1'b0 && rxIrq == 1'b1, "R9 rxRead clears complete only",
          {rxComplete, rxIrq}, 2'b01);
    pulse(rxIrqClr);
    check(rxIrq == 1'b0, "R9 rxIrqClr", rxIrq, 0);

    // R7: bad parity, line pulled in stop slot only
    cardSend(8'h4B, 1'b1, lp, ls, la);
    check(lp == 1'b0, "R7 no drive in parity slot", lp, 0);
    check(ls == 1'b1, "R7 drive in stop slot", ls, 1);
    check(la == 1'b0, "R7 drive released after stop", la, 0);
    check(parityErr == 1'b1 && rxData == 8'h4B && rxComplete, "R7 parityErr and data",
          {parityErr, rxData, rxComplete}, {1'b1, 8'h4B, 1'b1});
    pulse(errClr);
    check(parityErr == 1'b0, "R9 errClr clears parityErr", parityErr, 0);
    pulse(rxRead);
    pulse(rxIrqClr);

    // R10: receiver disabled
    rxEnable = 1'b0;
    cardSend(8'hF0, 1'b1, lp, ls, la);
    check(rxComplete == 1'b0 && rxData == 8'h4B && !ls, "R10 rx disabled ignores frame",
          {rxComplete, rxData, ls}, {1'b0, 8'h4B, 1'b0});

    // R8 echo: own frame received on the shared wire
    rxEnable = 1'b1;
    txEnable = 1'b1;
    writeTx(8'hC3);
    waitTxStart();
    captureTx(bits, 1'b0, mid);
    repeat (40) @(negedge clk);
    check(rxComplete && rxData == 8'hC3 && !parityErr, "R8 own frame echoed",
          {rxComplete, rxData, parityErr}, {1'b1, 8'hC3, 1'b0});
    pulse(rxRead);
    rxEnable = 1'b0;

    // R1/R3: bit length and start latency for two divisors
    foreach (bits[k]) ;  // no-op keeps bits used
    for (int dv = 0; dv < 4; dv += 3) begin
      int d;
      int len;
      baudDiv = 8'(dv);
      repeat (4) @(negedge clk);
      txData = 8'h01;
      txWrite = 1'b1;
      d = 0;
      do begin
        @(negedge clk);
        d++;
        if (d == 1) txWrite = 1'b0;
      end while (!lineOutLow && d < 200);
      check(d >= 2 && d <= dv + 2, "R3 start waits for overflow", d, dv + 2);
      len = 0;
      while (lineOutLow && len < 2000) begin
        @(negedge clk);
        len++;
      end
      check(len == 16 * (dv + 1), "R1 start bit length", len, 16 * (dv + 1));
      d = 0;
      while (!txRegEmpty && d < 4000) begin
        @(negedge clk);
        d++;
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule